// File: doc/BRIEF.md
# Tiled Pixel Address Generator

This block turns a pixel coordinate into the byte address of that pixel in memory, so that a following memory-side atomic operation can be aimed directly at one pixel of an image. Each request carries the address of pixel (0, 0), the X and Y coordinates, the byte distance between pixel rows, the pixel size as a power of two and a layout choice. Two layouts are supported. In row layout the pixels of a row are consecutive and rows follow each other. In tile layout the image is cut into square tiles of 2^k by 2^k pixels. Tiles are stored in row order, and inside a tile the pixels follow a Z-order curve obtained by bit-interleaving the low k bits of X and Y.

The block is a two-stage pipeline that accepts one request on every clock. The first stage splits the address into a row term, a column term and an in-tile term and registers them. The second stage sums these terms with the base address and presents the result with a valid strobe. Every request produces exactly one result two clocks later, and requests leave in the order they arrived. The tile layout assumes that the row distance covers a whole number of tiles. Under that assumption the byte offset of a tile row is the row distance times 2^k.

Top module: `tiled_pixel_addr`

## Requirements
- R1: With layout_sel = 0 (row layout), out_addr = base_addr + pix_y * row_stride + (pix_x << bpp_log2), taken modulo 2^40.
- R2: With layout_sel = 1 (tile layout) and tile size k = tile_log2, out_addr = base_addr + Yh * row_stride + (Xh << (k + bpp_log2)) + (M << bpp_log2), modulo 2^40. Here Xh and Yh are the coordinates with their low k bits cleared, and M is the interleaved in-tile index of R3.
- R3: The in-tile index M has bit 2i equal to pix_x[i] and bit 2i+1 equal to pix_y[i] for every i < k. All of its higher bits are zero, so at most the low 7 bits of each coordinate take part.
- R4: tile_log2 selects tiles of 2^k by 2^k pixels for k from 0 to 7. With k = 0, tile layout gives the same address as row layout.
- R5: bpp_log2 gives the pixel size as 2^bpp_log2 bytes. Both the column term and the in-tile index are scaled by this shift.
- R6: A request presented with in_valid high at a rising edge appears with out_valid high after the second following rising edge. out_valid is low in any cycle whose request slot two edges earlier was empty. One request is accepted per clock.
- R7: A request with pix_x = 0 and pix_y = 0 returns exactly base_addr in both layouts, for any stride, pixel size and tile size.
- R8: While rst_n is low, out_valid is 0 and out_addr is 0.
- R9: When out_valid is low, out_addr keeps the value of the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| base_addr | input | 40 | Byte address of pixel (0, 0) |
| pix_x | input | 16 | Pixel column |
| pix_y | input | 16 | Pixel row |
| row_stride | input | 24 | Bytes from one pixel row to the next |
| bpp_log2 | input | 3 | log2 of bytes per pixel |
| tile_log2 | input | 3 | log2 of tile edge in pixels (k) |
| layout_sel | input | 1 | 0 = row layout, 1 = tile layout |
| out_valid | output | 1 | Result strobe, two clocks after the request |
| out_addr | output | 40 | Computed pixel byte address |

## Verification
Random requests mix both layouts, all eight tile sizes, pixel sizes from 1 to 16 bytes, full-range coordinates and random gaps in the valid stream. Gaps exercise the pipeline timing and the hold of the last result. Directed cases target specific errors. Zero coordinates catch any stray term added to the base. Coordinates that stay inside one tile isolate the interleave and reveal swapped X/Y bit positions. A tile size of 0 compared against row layout shows that the tile and in-tile terms shrink to the row formula. The largest tile with all-ones coordinates exposes mask and shift width errors at the top of the range.

// File: rtl/tpag_pkg.sv
package tpag_pkg;
    typedef enum logic {
        LAYOUT_ROW  = 1'b0,
        LAYOUT_TILE = 1'b1
    } layout_e;

    localparam int DEF_ADDR_W    = 40;
    localparam int DEF_COORD_W   = 16;
    localparam int DEF_STRIDE_W  = 24;
    localparam int DEF_TILE_BITS = 7;
    localparam int DEF_BPP_W     = 3;
endpackage

// File: rtl/tpag_interleave.sv
module tpag_interleave #(
    parameter int COORD_W   = 16,
    parameter int TILE_BITS = 7,
    parameter int K_W       = 3
) (
    input  logic [COORD_W-1:0]     cx,
    input  logic [COORD_W-1:0]     cy,
    input  logic [K_W-1:0]         k_sel,
    output logic [2*TILE_BITS-1:0] zidx
);
    // Z-order: X on even positions, Y on odd positions, only for bit i < k
    for (genvar i = 0; i < TILE_BITS; i++) begin : g_bit
        assign zidx[2*i]   = (k_sel > K_W'(i)) ? cx[i] : 1'b0;
        assign zidx[2*i+1] = (k_sel > K_W'(i)) ? cy[i] : 1'b0;
    end
endmodule

// File: rtl/tpag_stage1.sv
module tpag_stage1
    import tpag_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int COORD_W   = DEF_COORD_W,
    parameter int STRIDE_W  = DEF_STRIDE_W,
    parameter int TILE_BITS = DEF_TILE_BITS,
    parameter int BPP_W     = DEF_BPP_W,
    parameter int K_W       = $clog2(TILE_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [COORD_W-1:0]  pix_x,
    input  logic [COORD_W-1:0]  pix_y,
    input  logic [STRIDE_W-1:0] row_stride,
    input  logic [BPP_W-1:0]    bpp_log2,
    input  logic [K_W-1:0]      tile_log2,
    input  logic                layout_sel,
    output logic                s1_valid,
    output logic [ADDR_W-1:0]   s1_base,
    output logic [ADDR_W-1:0]   s1_row,
    output logic [ADDR_W-1:0]   s1_col,
    output logic [ADDR_W-1:0]   s1_tile
);
    localparam int MORTON_W = 2 * TILE_BITS;
    localparam int SHIFT_W  = ((BPP_W > K_W) ? BPP_W : K_W) + 1;

    layout_e              mode;
    logic [COORD_W-1:0]   low_mask;
    logic [COORD_W-1:0]   x_hi;
    logic [COORD_W-1:0]   y_hi;
    logic [SHIFT_W-1:0]   col_shift;
    logic [MORTON_W-1:0]  zidx;
    logic [ADDR_W-1:0]    row_n;
    logic [ADDR_W-1:0]    col_n;
    logic [ADDR_W-1:0]    tile_n;

    tpag_interleave #(
        .COORD_W   (COORD_W),
        .TILE_BITS (TILE_BITS),
        .K_W       (K_W)
    ) u_zorder (
        .cx    (pix_x),
        .cy    (pix_y),
        .k_sel (tile_log2),
        .zidx  (zidx)
    );

    always_comb begin
        mode = layout_e'(layout_sel);
        unique case (mode)
            LAYOUT_TILE: begin
                low_mask  = ~({COORD_W{1'b1}} << tile_log2);
                col_shift = SHIFT_W'(bpp_log2) + SHIFT_W'(tile_log2);
                tile_n    = ADDR_W'(zidx) << bpp_log2;
            end
            default: begin
                low_mask  = '0;
                col_shift = SHIFT_W'(bpp_log2);
                tile_n    = '0;
            end
        endcase
        x_hi  = pix_x & ~low_mask;
        y_hi  = pix_y & ~low_mask;
        row_n = ADDR_W'(y_hi) * ADDR_W'(row_stride);
        col_n = ADDR_W'(x_hi) << col_shift;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_base  <= '0;
            s1_row   <= '0;
            s1_col   <= '0;
            s1_tile  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_base <= base_addr;
                s1_row  <= row_n;
                s1_col  <= col_n;
                s1_tile <= tile_n;
            end
        end
    end

    assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);

    assert_zero_terms_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pix_x == '0 && pix_y == '0)
            |=> (s1_row == '0 && s1_col == '0 && s1_tile == '0));

    assert_row_no_tile_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !layout_sel) |=> (s1_tile == '0));
endmodule

// File: rtl/tiled_pixel_addr.sv
module tiled_pixel_addr
    import tpag_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int COORD_W   = DEF_COORD_W,
    parameter int STRIDE_W  = DEF_STRIDE_W,
    parameter int TILE_BITS = DEF_TILE_BITS,
    parameter int BPP_W     = DEF_BPP_W,
    parameter int K_W       = $clog2(TILE_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [COORD_W-1:0]  pix_x,
    input  logic [COORD_W-1:0]  pix_y,
    input  logic [STRIDE_W-1:0] row_stride,
    input  logic [BPP_W-1:0]    bpp_log2,
    input  logic [K_W-1:0]      tile_log2,
    input  logic                layout_sel,
    output logic                out_valid,
    output logic [ADDR_W-1:0]   out_addr
);
    logic              s1_valid;
    logic [ADDR_W-1:0] s1_base;
    logic [ADDR_W-1:0] s1_row;
    logic [ADDR_W-1:0] s1_col;
    logic [ADDR_W-1:0] s1_tile;
    logic [ADDR_W-1:0] sum_n;

    tpag_stage1 #(
        .ADDR_W    (ADDR_W),
        .COORD_W   (COORD_W),
        .STRIDE_W  (STRIDE_W),
        .TILE_BITS (TILE_BITS),
        .BPP_W     (BPP_W),
        .K_W       (K_W)
    ) u_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .base_addr  (base_addr),
        .pix_x      (pix_x),
        .pix_y      (pix_y),
        .row_stride (row_stride),
        .bpp_log2   (bpp_log2),
        .tile_log2  (tile_log2),
        .layout_sel (layout_sel),
        .s1_valid   (s1_valid),
        .s1_base    (s1_base),
        .s1_row     (s1_row),
        .s1_col     (s1_col),
        .s1_tile    (s1_tile)
    );

    always_comb begin
        sum_n = s1_base + s1_row + s1_col + s1_tile;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_addr <= sum_n;
            end
        end
    end

    assert_emit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);

    assert_no_phantom_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !out_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> $stable(out_addr));
endmodule

// File: tb/tiled_pixel_addr_tb.sv
module tiled_pixel_addr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [39:0] base_addr = '0;
    logic [15:0] pix_x = '0;
    logic [15:0] pix_y = '0;
    logic [23:0] row_stride = '0;
    logic [2:0]  bpp_log2 = '0;
    logic [2:0]  tile_log2 = '0;
    logic        layout_sel = 1'b0;
    logic        out_valid;
    logic [39:0] out_addr;

    int checks = 0;
    int errors = 0;
    bit checking = 1'b0;

    // expected pipeline state
    logic        m1_v = 1'b0, mo_v = 1'b0;
    logic [39:0] m1_a = '0, mo_a = '0;
    string       m1_tag = "R1", mo_tag = "R1";

    always #10 clk = ~clk;

    tiled_pixel_addr dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_addr(base_addr),
        .pix_x(pix_x), .pix_y(pix_y), .row_stride(row_stride), .bpp_log2(bpp_log2),
        .tile_log2(tile_log2), .layout_sel(layout_sel),
        .out_valid(out_valid), .out_addr(out_addr)
    );

    function automatic logic [39:0] ref_addr(input logic [39:0] b, input logic [15:0] px,
        input logic [15:0] py, input logic [23:0] st, input int bp, input int kk, input bit tl);
        logic [39:0] off;
        logic [13:0] m;
        logic [15:0] xh, yh;
        if (!tl) begin
            off = 40'(py) * 40'(st) + (40'(px) << bp);
        end else begin
            m = '0;
            for (int i = 0; i < kk; i++) begin
                m[2*i]   = px[i];
                m[2*i+1] = py[i];
            end
            xh  = (px >> kk) << kk;
            yh  = (py >> kk) << kk;
            off = 40'(yh) * 40'(st) + (40'(xh) << (kk + bp)) + (40'(m) << bp);
        end
        return b + off;
    endfunction

    function automatic string pick_tag(input logic [15:0] px, input logic [15:0] py,
        input int bp, input int kk, input bit tl);
        if (px == 0 && py == 0) return "R7";
        if (tl && kk == 0) return "R4";
        if (tl && px < (16'd1 << kk) && py < (16'd1 << kk)) return "R3";
        if (tl) return "R2";
        if (bp != 0) return "R5";
        return "R1";
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1_v <= 1'b0; mo_v <= 1'b0; m1_a <= '0; mo_a <= '0;
        end else begin
            m1_v <= in_valid;
            if (in_valid) begin
                m1_a   <= ref_addr(base_addr, pix_x, pix_y, row_stride,
                                   int'(bpp_log2), int'(tile_log2), layout_sel);
                m1_tag <= pick_tag(pix_x, pix_y, int'(bpp_log2), int'(tile_log2), layout_sel);
            end
            mo_v <= m1_v;
            if (m1_v) begin
                mo_a   <= m1_a;
                mo_tag <= m1_tag;
            end
        end
    end

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            check("R6", 40'(out_valid), 40'(mo_v));
            if (mo_v) check(mo_tag, out_addr, mo_a);
            else      check("R9", out_addr, mo_a);
        end
    end

    task automatic req(input bit v, input logic [39:0] b, input logic [15:0] px,
        input logic [15:0] py, input logic [23:0] st, input int bp, input int kk, input bit tl);
        @(negedge clk);
        in_valid   = v;
        base_addr  = b;
        pix_x      = px;
        pix_y      = py;
        row_stride = st;
        bpp_log2   = 3'(bp);
        tile_log2  = 3'(kk);
        layout_sel = tl;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8", 40'(out_valid), 40'd0);
        check("R8", out_addr, 40'd0);
        rst_n = 1'b1;
        checking = 1'b1;
        // R7: zero coordinates in both layouts
        req(1, 40'hAB_1234_5678, 0, 0, 24'd4096, 2, 0, 0);
        req(1, 40'hFF_FFFF_FFC0, 0, 0, 24'hFFFFFF, 4, 7, 1);
        // R4: k = 0 tile layout against row layout
        req(1, 40'h10_0000_0000, 16'd37, 16'd11, 24'd1024, 2, 0, 1);
        req(1, 40'h10_0000_0000, 16'd37, 16'd11, 24'd1024, 2, 0, 0);
        // R3: in-tile only, X on even bits, Y on odd bits
        req(1, 40'h0, 16'h0001, 16'h0000, 24'd512, 0, 3, 1);
        req(1, 40'h0, 16'h0000, 16'h0001, 24'd512, 0, 3, 1);
        req(1, 40'h0, 16'h007F, 16'h0000, 24'd512, 0, 7, 1);
        // R2 / R5: large tile, all-ones coordinates, big pixels
        req(1, 40'h01_0000_0000, 16'hFFFF, 16'hFFFF, 24'd65536, 4, 7, 1);
        req(1, 40'h01_0000_0000, 16'hFFFF, 16'hFFFF, 24'hFFFFFF, 4, 0, 0);
        // R9: gap in the stream
        req(0, 40'h55, 16'd9, 16'd9, 24'd9, 1, 1, 1);
        req(0, 40'h66, 16'd3, 16'd3, 24'd3, 1, 1, 0);
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            req(($urandom % 4) != 0, {8'($urandom), 32'($urandom)}, 16'($urandom),
                16'($urandom), 24'($urandom), int'($urandom % 5), int'($urandom % 8),
                1'($urandom));
        end
        req(0, '0, '0, '0, '0, 0, 0, 0);
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule